// File: doc/BRIEF.md
# Serial Transmit Holding Buffer Controller

This block sits between a host and the transmit shift unit of a serial engine that can run as UART, SPI master, SPI slave or I2C. It keeps one pending transmit word together with a port-direction bit that arrives in the same host write. It tracks whether that word is still waiting. It also decides, cycle by cycle, whether the word may be handed to the shift unit under the rules of the selected protocol.

When the shift unit reports that it is idle and the protocol's start condition is met, the block raises a one-cycle load strobe. During that strobe it presents the held data. The direction bit travels with the word and reaches the pin-driver output only when the word is taken. A software reset input throws away a word that has not been sent, so the host can replace it. The host may refill the buffer while an earlier word is still being shifted out.

Top module: `sertx_hold_ctrl`

## Requirements
- R1: After reset, `buf_empty` is 1, `ld_stb` is 0 and `dir_out` is 0.
- R2: A host write (`wr_en`=1, `tx_rst`=0) makes `buf_empty` 0 on the next cycle. `ld_data` then shows `wr_word[DATA_W-1:0]`, and the word's direction bit is taken from `wr_word[DATA_W]` (bit 16 by default).
- R3: `ld_stb` is 1 only when all four of these hold: the buffer is non-empty, `shf_ready` is 1, `tx_rst` is 0, and the protocol condition below is met.
- R4: Protocol code 0 (UART): with `flow_en`=0 a non-empty buffer is enough. With `flow_en`=1, `flow_in` must also equal its active level (`FLOW_ACT_LVL`, default 0).
- R5: Protocol codes 1 (SPI master) and 3 (I2C): a non-empty buffer is enough.
- R6: Protocol code 2 (SPI slave): both `ss_act` and `sclk_edge` must also be 1.
- R7: After a cycle with `ld_stb`=1 and no host write, `buf_empty` is 1. If a host write lands in the load cycle, the new word is held and `buf_empty` stays 0.
- R8: `tx_rst`=1 makes `buf_empty` 1 on the next cycle. This also holds when a host write comes in the same cycle, and no load occurs in that cycle.
- R9: `dir_out` changes only in the cycle after a load. It then takes the direction bit of the word that was loaded. A host write alone leaves `dir_out` unchanged.
- R10: A host write while a word is already waiting and the shifter is busy replaces the held word and direction bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| proto_sel | input | 2 | Protocol code: 0 UART, 1 SPI master, 2 SPI slave, 3 I2C |
| flow_en | input | 1 | UART automatic flow control enable |
| flow_in | input | 1 | UART flow-control line from the peer |
| ss_act | input | 1 | SPI slave select is active |
| sclk_edge | input | 1 | SPI slave sees a clock edge on its clock pin |
| wr_en | input | 1 | Host write strobe |
| wr_word | input | DATA_W+1 (17) | Host write word: data in the low bits, direction in the top bit |
| tx_rst | input | 1 | Software reset of the transmit buffer |
| shf_ready | input | 1 | Shift unit is idle and can take a word |
| ld_stb | output | 1 | Load strobe to the shift unit |
| ld_data | output | DATA_W (16) | Held data word |
| dir_out | output | 1 | Port direction applied to the pin driver |
| buf_empty | output | 1 | Buffer holds no pending word |

## Verification
Assertions check four things on every cycle. A strobe never fires from an empty buffer. Every strobe meets the flow-control and slave-select/clock conditions of its protocol. The empty flag follows writes, loads and resets in the following cycle. The direction output holds still except after a load. Some behaviour needs the bench's reference model and scenarios. These are strobe-presence cases: whether a permitted load is actually issued. They also include that `ld_data` matches the last written word, that a write in a load cycle wins, and that `dir_out` carries the direction of the word that was taken rather than the one written later.

// File: rtl/sertx_pkg.sv
package sertx_pkg;
   typedef enum logic [1:0] {
      PROTO_UART    = 2'd0,
      PROTO_SPI_MST = 2'd1,
      PROTO_SPI_SLV = 2'd2,
      PROTO_I2C     = 2'd3
   } proto_e;

   localparam int unsigned SERTX_MAX_W = 32;
endpackage

// File: rtl/sertx_hold_reg.sv
module sertx_hold_reg #(
   parameter int unsigned DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W:0]   wr_word,
   input  logic              tx_rst,
   input  logic              take,
   output logic [DATA_W-1:0] hold_data,
   output logic              hold_dir,
   output logic              empty
);
   localparam int unsigned DIR_POS = DATA_W;

   logic wr_acc;
   assign wr_acc = wr_en && !tx_rst;

   // storage for word and direction: written only on an accepted write
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_data <= '0;
         hold_dir  <= 1'b0;
      end else if (wr_acc) begin
         hold_data <= wr_word[DATA_W-1:0];
         hold_dir  <= wr_word[DIR_POS];
      end
   end

   // empty flag: reset beats write, write beats take
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      empty <= 1'b1;
      else if (tx_rst) empty <= 1'b1;
      else if (wr_en)  empty <= 1'b0;
      else if (take)   empty <= 1'b1;
   end

   AST_WR_CLEARS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      wr_acc |=> !empty); // R2
   AST_RST_SETS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      tx_rst |=> empty); // R8
   AST_TAKE_SETS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      (take && !wr_en) |=> empty); // R7
   AST_WR_IN_TAKE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      (take && wr_acc) |=> !empty); // R7
endmodule

// File: rtl/sertx_start_gate.sv
module sertx_start_gate
   import sertx_pkg::*;
#(
   parameter bit HAS_FLOW     = 1'b1,
   parameter bit FLOW_ACT_LVL = 1'b0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] proto_sel,
   input  logic       flow_en,
   input  logic       flow_in,
   input  logic       ss_act,
   input  logic       sclk_edge,
   input  logic       empty,
   input  logic       shf_ready,
   input  logic       tx_rst,
   output logic       ld_ok
);
   proto_e proto;
   logic   uart_ok;
   logic   slv_ok;
   logic   proto_ok;

   assign proto = proto_e'(proto_sel);

   generate
      if (HAS_FLOW) begin : g_flow
         assign uart_ok = !flow_en || (flow_in == FLOW_ACT_LVL);
      end else begin : g_noflow
         assign uart_ok = 1'b1;
      end
   endgenerate

   assign slv_ok = ss_act && sclk_edge;

   always_comb begin
      unique case (proto)
         PROTO_UART:    proto_ok = uart_ok;
         PROTO_SPI_MST: proto_ok = 1'b1;
         PROTO_SPI_SLV: proto_ok = slv_ok;
         PROTO_I2C:     proto_ok = 1'b1;
         default:       proto_ok = 1'b0;
      endcase
   end

   assign ld_ok = !empty && shf_ready && !tx_rst && proto_ok;

   AST_SLAVE_NEEDS_SS_CLK: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_ok && proto == PROTO_SPI_SLV) |-> (ss_act && sclk_edge)); // R6
   AST_FLOW_HONOURED: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_ok && proto == PROTO_UART && flow_en && HAS_FLOW) |-> (flow_in == FLOW_ACT_LVL)); // R4
   AST_NO_LOAD_IN_RST: assert property (@(posedge clk) disable iff (!rst_n)
      tx_rst |-> !ld_ok); // R8
endmodule

// File: rtl/sertx_dir_latch.sv
module sertx_dir_latch (
   input  logic clk,
   input  logic rst_n,
   input  logic take,
   input  logic dir_in,
   output logic dir_out
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    dir_out <= 1'b0;
      else if (take) dir_out <= dir_in;
   end

   AST_DIR_ONLY_ON_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      !take |=> $stable(dir_out)); // R9
endmodule

// File: rtl/sertx_hold_ctrl.sv
module sertx_hold_ctrl
   import sertx_pkg::*;
#(
   parameter int unsigned DATA_W       = 16,
   parameter bit          HAS_FLOW     = 1'b1,
   parameter bit          FLOW_ACT_LVL = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        proto_sel,
   input  logic              flow_en,
   input  logic              flow_in,
   input  logic              ss_act,
   input  logic              sclk_edge,
   input  logic              wr_en,
   input  logic [DATA_W:0]   wr_word,
   input  logic              tx_rst,
   input  logic              shf_ready,
   output logic              ld_stb,
   output logic [DATA_W-1:0] ld_data,
   output logic              dir_out,
   output logic              buf_empty
);
   generate
      if (DATA_W < 4 || DATA_W > SERTX_MAX_W) begin : g_bad_width
         $error("sertx_hold_ctrl: DATA_W out of range");
      end
   endgenerate

   logic              take;
   logic              empty;
   logic              hold_dir;
   logic [DATA_W-1:0] hold_data;

   sertx_hold_reg #(.DATA_W(DATA_W)) u_hold (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .wr_word   (wr_word),
      .tx_rst    (tx_rst),
      .take      (take),
      .hold_data (hold_data),
      .hold_dir  (hold_dir),
      .empty     (empty)
   );

   sertx_start_gate #(.HAS_FLOW(HAS_FLOW), .FLOW_ACT_LVL(FLOW_ACT_LVL)) u_gate (
      .clk       (clk),
      .rst_n     (rst_n),
      .proto_sel (proto_sel),
      .flow_en   (flow_en),
      .flow_in   (flow_in),
      .ss_act    (ss_act),
      .sclk_edge (sclk_edge),
      .empty     (empty),
      .shf_ready (shf_ready),
      .tx_rst    (tx_rst),
      .ld_ok     (take)
   );

   sertx_dir_latch u_dir (
      .clk     (clk),
      .rst_n   (rst_n),
      .take    (take),
      .dir_in  (hold_dir),
      .dir_out (dir_out)
   );

   assign ld_stb    = take;
   assign ld_data   = hold_data;
   assign buf_empty = empty;

   AST_LOAD_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      ld_stb |-> (!buf_empty && shf_ready)); // R3
   AST_DIR_FOLLOWS_WORD: assert property (@(posedge clk) disable iff (!rst_n)
      ld_stb |=> (dir_out == $past(hold_dir))); // R9
endmodule

// File: tb/sertx_hold_ctrl_test.sv
`timescale 1ns/1ps
module sertx_hold_ctrl_test;
   localparam int unsigned DW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [1:0]    proto_sel = 2'd0;
   logic          flow_en = 1'b0, flow_in = 1'b0, ss_act = 1'b0, sclk_edge = 1'b0;
   logic          wr_en = 1'b0, tx_rst = 1'b0, shf_ready = 1'b0;
   logic [DW:0]   wr_word = '0;
   logic          ld_stb, dir_out, buf_empty;
   logic [DW-1:0] ld_data;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   // reference state
   bit          m_empty = 1'b1;
   bit          m_dir = 1'b0;
   bit          m_dir_out = 1'b0;
   logic [DW-1:0] m_data = '0;

   always #2.5 clk = ~clk;

   sertx_hold_ctrl uut (
      .clk(clk), .rst_n(rst_n), .proto_sel(proto_sel), .flow_en(flow_en),
      .flow_in(flow_in), .ss_act(ss_act), .sclk_edge(sclk_edge), .wr_en(wr_en),
      .wr_word(wr_word), .tx_rst(tx_rst), .shf_ready(shf_ready), .ld_stb(ld_stb),
      .ld_data(ld_data), .dir_out(dir_out), .buf_empty(buf_empty)
   );

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s got=%0h exp=%0h at %0t", tag, got, exp, $time);
      end
   endtask

   function automatic bit gate_f(input logic [1:0] p);
      case (p)
         2'd0:    return !flow_en || (flow_in == 1'b0);
         2'd2:    return ss_act && sclk_edge;
         default: return 1'b1;
      endcase
   endfunction

   function automatic string ld_tag(input logic [1:0] p);
      case (p)
         2'd0:    return "R4";
         2'd2:    return "R6";
         default: return "R5";
      endcase
   endfunction

   // inputs already driven at negedge; compare then advance model
   task automatic step_check(input string empty_tag);
      bit exp_ld;
      #1;
      exp_ld = !m_empty && shf_ready && !tx_rst && gate_f(proto_sel);
      chk(ld_tag(proto_sel), ld_stb, exp_ld);
      chk(empty_tag, buf_empty, m_empty);
      chk("R9", dir_out, m_dir_out);
      if (!m_empty) chk("R2", ld_data, m_data);
      if (exp_ld) m_dir_out = m_dir;
      if (tx_rst) m_empty = 1'b1;
      else if (wr_en) begin
         m_empty = 1'b0;
         m_data  = wr_word[DW-1:0];
         m_dir   = wr_word[DW];
      end else if (exp_ld) m_empty = 1'b1;
      @(posedge clk);
   endtask

   task automatic drive(input logic [1:0] p, input bit fe, input bit fi, input bit ss,
                        input bit se, input bit we, input logic [DW:0] w,
                        input bit rs, input bit rdy, input string tag);
      @(negedge clk);
      proto_sel = p; flow_en = fe; flow_in = fi; ss_act = ss; sclk_edge = se;
      wr_en = we; wr_word = w; tx_rst = rs; shf_ready = rdy;
      step_check(tag);
   endtask

   initial begin
      void'($urandom(32'h5EED_1234));
      repeat (3) @(posedge clk);
      #1;
      chk("R1", buf_empty, 1'b1);
      chk("R1", ld_stb, 1'b0);
      chk("R1", dir_out, 1'b0);
      @(negedge clk); rst_n = 1'b1;

      // R3: write with shifter busy -> no load
      drive(2'd1, 0, 0, 0, 0, 1, 17'h1A5A5, 0, 0, "R2");
      drive(2'd1, 0, 0, 0, 0, 0, '0, 0, 0, "R3");
      // R10: overwrite while waiting and shifter busy
      drive(2'd1, 0, 0, 0, 0, 1, 17'h03C3C, 0, 0, "R10");
      drive(2'd1, 0, 0, 0, 0, 0, '0, 0, 0, "R10");
      // R6: slave with select but no clock edge, then both
      drive(2'd2, 0, 0, 1, 0, 0, '0, 0, 1, "R6");
      drive(2'd2, 0, 0, 1, 1, 0, '0, 0, 1, "R6");
      drive(2'd2, 0, 0, 0, 0, 0, '0, 0, 0, "R7");
      // R4: flow control inactive blocks, active allows
      drive(2'd0, 1, 1, 0, 0, 1, 17'h1BEEF, 0, 1, "R2");
      drive(2'd0, 1, 1, 0, 0, 0, '0, 0, 1, "R4");
      // R7: load and write in same cycle -> stays full
      drive(2'd0, 1, 0, 0, 0, 1, 17'h01234, 0, 1, "R4");
      drive(2'd3, 0, 0, 0, 0, 0, '0, 0, 0, "R7");
      // R8: reset together with write and ready shifter
      drive(2'd3, 0, 0, 0, 0, 1, 17'h15555, 1, 1, "R7");
      drive(2'd3, 0, 0, 0, 0, 0, '0, 0, 1, "R8");

      for (int i = 0; i < 4000; i++) begin
         drive(2'($urandom_range(0, 3)), 1'($urandom), 1'($urandom), 1'($urandom),
               1'($urandom), ($urandom_range(0, 2) == 0), 17'($urandom),
               ($urandom_range(0, 15) == 0), ($urandom_range(0, 3) != 0), "R7");
      end

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule